// File: doc/BRIEF.md
# Ethernet Receive Status and Frame Filter

This block sits at the end of an Ethernet MAC receive path. When a frame ends, it gathers that frame's attributes and forms a 32-bit status word. The attributes are its EtherType, its destination class, the hits from the address recognizer and from an external lookup table, its byte length and its CRC result. In the same step it decides whether the frame is kept or discarded. The decision comes with a 4-bit reason code, so software can see which rule fired in each of the three filtering modes.

Event bits are sticky. They hold from the end of one frame until the next frame starts or a soft reset occurs. An interrupt output follows a small enable mask. A frame that the filter discards still sets the receive-event bit, but it never raises the interrupt. The block has no data stream: every input is a plain level that is sampled in the cycle the end-of-frame strobe is high, and every output is a plain register. No valid/ready back-pressure applies.

Top module: `rx_status_filter`

## Requirements
- R1: A soft reset, or the asynchronous reset, sets the status word to 0x3E00_8000 and drives the interrupt low in the following cycle.
- R2: A start-of-frame strobe without an end-of-frame strobe clears the status word and the interrupt to 0 in the following cycle.
- R3: The result-valid output pulses for exactly one cycle, in the cycle after the end-of-frame strobe. The status word and the interrupt then hold unchanged until the next start of frame or soft reset, whatever the other inputs do.
- R4: A frame with EtherType 0x8808 is discarded with code 0000 when pass-control is off. Status bit 5 (control received) is set when the EtherType is 0x8808 and the address recognizer hits.
- R5: When no R4 discard applies, a frame shorter than 6 bytes is discarded with code 0111 if short-frame mode is off, and with code 0001 if it is on. A frame of at least 6 bytes that is shorter than the minimum is discarded with code 0001. The minimum is 64 bytes, or 14 bytes in short-frame mode.
- R6: Inverse mode (mode 00) discards a frame on a recognizer hit (code 0010). Without a recognizer hit it discards on a lookup-table hit (code 0100). Otherwise it keeps the frame with code 1110.
- R7: AND mode (mode 01) keeps a frame on a recognizer hit (1010) or a lookup-table hit (1100). With neither hit, it discards the frame with code 0110 while compare-enable is set, and keeps it with code 1110 when compare-enable is clear.
- R8: Accept mode (mode 10) keeps a frame with code 1000 when the recognizer hits and the frame's class is enabled in the accept mask (bit 0 unicast, bit 1 multicast, bit 2 broadcast; broadcast takes precedence over multicast). All other cases, including mode 11, give discard code 0001. The reserved codes 0011, 0101, 1001, 1011, 1101 and 1111 are never produced.
- R9: The status word holds the following fields. Bits 3:0 hold the code. Bit 4 is the keep flag and equals code bit 3. Bit 7 is the CRC error and bit 8 is good (no CRC error). Bit 17 is multicast and bit 18 is broadcast, and both at 0 mean unicast. All other bits are 0. The code and keep outputs mirror bits 3:0 and bit 4.
- R10: Status bit 6 (receive event) is set when an enabled event occurs: enable bit 0 for control received, bit 1 for CRC error, bit 2 for good. The interrupt is set only when the receive event is set and the frame is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset; loads the reset status value |
| sof | input | 1 | Start-of-frame strobe |
| eof | input | 1 | End-of-frame strobe; frame inputs are sampled with it |
| ethertype | input | 16 | EtherType of the frame |
| is_bcast | input | 1 | Destination is broadcast |
| is_mcast | input | 1 | Destination is multicast |
| arc_hit | input | 1 | Address recognizer hit |
| cam_hit | input | 1 | External lookup table hit |
| cmp_en | input | 1 | Address compare enable (AND mode) |
| filt_mode | input | 2 | 00 inverse, 01 AND, 10 accept, 11 reserved |
| acc_mask | input | 3 | Accept mask: unicast, multicast, broadcast |
| pass_ctl | input | 1 | Pass MAC control frames |
| short_en | input | 1 | Short-frame mode (14-byte minimum) |
| frame_len | input | LEN_W | Received frame length in bytes |
| crc_err | input | 1 | CRC error on the frame |
| irq_en | input | 3 | Event enables: control, CRC error, good |
| status | output | 32 | Sticky status word |
| filt_code | output | 4 | Keep/discard reason code |
| keep | output | 1 | Frame kept |
| res_vld | output | 1 | One-cycle pulse after end of frame |
| irq | output | 1 | Receive interrupt |

## Verification
Random frames cover all four mode values. Each frame has an independent mix of recognizer and lookup-table hits, destination classes, accept masks, CRC results and compare enables. These frames separate the hit priority inside each mode and the inverse, AND and accept interpretations of the same hits. The lengths cluster around 6, 14 and 64 bytes, and about a quarter of the frames are control frames, so the length and control rules are tested against the mode rules that rank below them. Directed frames test the following:
- each boundary length on both sides of short-frame mode;
- a control frame with pass-control on and off;
- a discarded frame with every event enabled, which must show the receive-event bit with no interrupt;
- inputs changed after the result, which show whether the status word holds.

// File: rtl/rxsf_pkg.sv
package rxsf_pkg;
  typedef enum logic [1:0] {
    MODE_INV = 2'b00,
    MODE_AND = 2'b01,
    MODE_ACC = 2'b10,
    MODE_RSV = 2'b11
  } filt_mode_e;

  // reason codes; bit 3 set means keep
  localparam logic [3:0] C_CTL_TOSS   = 4'b0000;
  localparam logic [3:0] C_SHORT      = 4'b0001;
  localparam logic [3:0] C_INV_ARC    = 4'b0010;
  localparam logic [3:0] C_INV_CAM    = 4'b0100;
  localparam logic [3:0] C_AND_MISS   = 4'b0110;
  localparam logic [3:0] C_RUNT       = 4'b0111;
  localparam logic [3:0] C_ACC_KEEP   = 4'b1000;
  localparam logic [3:0] C_AND_ARC    = 4'b1010;
  localparam logic [3:0] C_AND_CAM    = 4'b1100;
  localparam logic [3:0] C_NOMATCH_OK = 4'b1110;

  localparam logic [15:0] ETYPE_MAC_CTL = 16'h8808;

  // status word bit positions
  localparam int B_KEEP  = 4;
  localparam int B_CTL   = 5;
  localparam int B_EVT   = 6;
  localparam int B_CRC   = 7;
  localparam int B_GOOD  = 8;
  localparam int B_MCAST = 17;
  localparam int B_BCAST = 18;
endpackage

// File: rtl/rxsf_decide.sv
module rxsf_decide
  import rxsf_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int MIN_LEN   = 64,
  parameter int MIN_SHORT = 14,
  parameter int MIN_HDR   = 6
) (
  input  logic [15:0]      ethertype,
  input  logic             is_bcast,
  input  logic             is_mcast,
  input  logic             arc_hit,
  input  logic             cam_hit,
  input  logic             cmp_en,
  input  logic [1:0]       filt_mode,
  input  logic [2:0]       acc_mask,
  input  logic             pass_ctl,
  input  logic             short_en,
  input  logic [LEN_W-1:0] frame_len,
  output logic [3:0]       code,
  output logic             ctl_rcvd
);
  localparam logic [LEN_W-1:0] L_HDR   = LEN_W'(MIN_HDR);
  localparam logic [LEN_W-1:0] L_MIN   = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] L_SHORT = LEN_W'(MIN_SHORT);

  logic is_ctl, below_hdr, below_min, class_ok;

  assign is_ctl    = (ethertype == ETYPE_MAC_CTL);
  assign ctl_rcvd  = is_ctl && arc_hit;
  assign below_hdr = (frame_len < L_HDR);
  assign below_min = (frame_len < (short_en ? L_SHORT : L_MIN));
  assign class_ok  = is_bcast ? acc_mask[2] : (is_mcast ? acc_mask[1] : acc_mask[0]);

  always_comb begin
    code = C_SHORT;
    if (is_ctl && !pass_ctl)      code = C_CTL_TOSS;
    else if (below_hdr)           code = short_en ? C_SHORT : C_RUNT;
    else if (below_min)           code = C_SHORT;
    else begin
      unique case (filt_mode_e'(filt_mode))
        MODE_INV: code = arc_hit ? C_INV_ARC : (cam_hit ? C_INV_CAM : C_NOMATCH_OK);
        MODE_AND: code = arc_hit ? C_AND_ARC : (cam_hit ? C_AND_CAM :
                         (cmp_en ? C_AND_MISS : C_NOMATCH_OK));
        MODE_ACC: code = (arc_hit && class_ok) ? C_ACC_KEEP : C_SHORT;
        default:  code = C_SHORT;
      endcase
    end
  end
endmodule

// File: rtl/rxsf_event.sv
module rxsf_event #(
  parameter int N_EVT = 3
) (
  input  logic [N_EVT-1:0] evt,
  input  logic [N_EVT-1:0] evt_en,
  input  logic             kept,
  output logic             rx_event,
  output logic             irq_next
);
  logic [N_EVT-1:0] armed;

  for (genvar i = 0; i < N_EVT; i++) begin : g_arm
    assign armed[i] = evt[i] & evt_en[i];
  end

  assign rx_event = |armed;
  assign irq_next = rx_event & kept;
endmodule

// File: rtl/rx_status_filter.sv
module rx_status_filter
  import rxsf_pkg::*;
#(
  parameter int          LEN_W     = 11,
  parameter int          MIN_LEN   = 64,
  parameter int          MIN_SHORT = 14,
  parameter int          MIN_HDR   = 6,
  parameter logic [31:0] RESET_VAL = 32'h3E00_8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             sof,
  input  logic             eof,
  input  logic [15:0]      ethertype,
  input  logic             is_bcast,
  input  logic             is_mcast,
  input  logic             arc_hit,
  input  logic             cam_hit,
  input  logic             cmp_en,
  input  logic [1:0]       filt_mode,
  input  logic [2:0]       acc_mask,
  input  logic             pass_ctl,
  input  logic             short_en,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             crc_err,
  input  logic [2:0]       irq_en,
  output logic [31:0]      status,
  output logic [3:0]       filt_code,
  output logic             keep,
  output logic             res_vld,
  output logic             irq
);
  logic [3:0]  code_n;
  logic        ctl_n, evt_n, irq_n, good_n;
  logic [31:0] word_n;

  rxsf_decide #(
    .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MIN_SHORT(MIN_SHORT), .MIN_HDR(MIN_HDR)
  ) u_decide (
    .ethertype(ethertype), .is_bcast(is_bcast), .is_mcast(is_mcast),
    .arc_hit(arc_hit), .cam_hit(cam_hit), .cmp_en(cmp_en),
    .filt_mode(filt_mode), .acc_mask(acc_mask), .pass_ctl(pass_ctl),
    .short_en(short_en), .frame_len(frame_len),
    .code(code_n), .ctl_rcvd(ctl_n)
  );

  assign good_n = !crc_err;

  rxsf_event #(.N_EVT(3)) u_event (
    .evt({good_n, crc_err, ctl_n}),
    .evt_en(irq_en),
    .kept(code_n[3]),
    .rx_event(evt_n),
    .irq_next(irq_n)
  );

  always_comb begin
    word_n          = '0;
    word_n[3:0]     = code_n;
    word_n[B_KEEP]  = code_n[3];
    word_n[B_CTL]   = ctl_n;
    word_n[B_EVT]   = evt_n;
    word_n[B_CRC]   = crc_err;
    word_n[B_GOOD]  = good_n;
    word_n[B_MCAST] = is_mcast;
    word_n[B_BCAST] = is_bcast;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status  <= RESET_VAL;
      irq     <= 1'b0;
      res_vld <= 1'b0;
    end else if (soft_rst) begin
      status  <= RESET_VAL;
      irq     <= 1'b0;
      res_vld <= 1'b0;
    end else if (eof) begin
      status  <= word_n;
      irq     <= irq_n;
      res_vld <= 1'b1;
    end else if (sof) begin
      status  <= '0;
      irq     <= 1'b0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= 1'b0;
    end
  end

  assign filt_code = status[3:0];
  assign keep      = status[B_KEEP];
endmodule

// File: rtl/rx_status_filter_chk.sv
module rx_status_filter_chk #(
  parameter logic [31:0] RESET_VAL = 32'h3E00_8000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        sof,
  input logic        eof,
  input logic [15:0] ethertype,
  input logic        pass_ctl,
  input logic [31:0] status,
  input logic [3:0]  filt_code,
  input logic        keep,
  input logic        res_vld,
  input logic        irq
);
  p_reset_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (status == RESET_VAL) && !irq);

  p_clear_on_sof_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !eof && !soft_rst) |=> (status == 32'h0) && !irq);

  p_result_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && !soft_rst) |=> res_vld);

  p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof && !eof && !soft_rst) |=> $stable(status) && $stable(irq) && !res_vld);

  p_ctl_toss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && !soft_rst && ethertype == 16'h8808 && !pass_ctl) |=> (filt_code == 4'b0000) && !keep);

  p_legal_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (filt_code inside {4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b0110,
                                   4'b0111, 4'b1000, 4'b1010, 4'b1100, 4'b1110}));

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> keep && status[6]);
endmodule

bind rx_status_filter rx_status_filter_chk #(.RESET_VAL(RESET_VAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .sof(sof), .eof(eof),
  .ethertype(ethertype), .pass_ctl(pass_ctl), .status(status),
  .filt_code(filt_code), .keep(keep), .res_vld(res_vld), .irq(irq)
);

// File: tb/rx_status_filter_tb_top.sv
module rx_status_filter_tb_top;
  localparam int LEN_W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0, sof = 1'b0, eof = 1'b0;
  logic [15:0] ethertype = 16'h0800;
  logic is_bcast = 1'b0, is_mcast = 1'b0, arc_hit = 1'b0, cam_hit = 1'b0, cmp_en = 1'b0;
  logic [1:0] filt_mode = 2'b00;
  logic [2:0] acc_mask = 3'b000;
  logic pass_ctl = 1'b0, short_en = 1'b0, crc_err = 1'b0;
  logic [LEN_W-1:0] frame_len = 11'd64;
  logic [2:0] irq_en = 3'b000;
  logic [31:0] status;
  logic [3:0] filt_code;
  logic keep, res_vld, irq;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_status_filter dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .sof(sof), .eof(eof),
    .ethertype(ethertype), .is_bcast(is_bcast), .is_mcast(is_mcast),
    .arc_hit(arc_hit), .cam_hit(cam_hit), .cmp_en(cmp_en),
    .filt_mode(filt_mode), .acc_mask(acc_mask), .pass_ctl(pass_ctl),
    .short_en(short_en), .frame_len(frame_len), .crc_err(crc_err),
    .irq_en(irq_en), .status(status), .filt_code(filt_code), .keep(keep),
    .res_vld(res_vld), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected reason code, from R4..R8
  function automatic logic [3:0] exp_code();
    logic cls;
    int   minl;
    minl = short_en ? 14 : 64;
    cls  = is_bcast ? acc_mask[2] : (is_mcast ? acc_mask[1] : acc_mask[0]);
    if (ethertype == 16'h8808 && !pass_ctl) return 4'b0000;
    if (int'(frame_len) < 6) return short_en ? 4'b0001 : 4'b0111;
    if (int'(frame_len) < minl) return 4'b0001;
    case (filt_mode)
      2'b00: begin
        if (arc_hit) return 4'b0010;
        if (cam_hit) return 4'b0100;
        return 4'b1110;
      end
      2'b01: begin
        if (arc_hit) return 4'b1010;
        if (cam_hit) return 4'b1100;
        return cmp_en ? 4'b0110 : 4'b1110;
      end
      2'b10: return (arc_hit && cls) ? 4'b1000 : 4'b0001;
      default: return 4'b0001;
    endcase
  endfunction

  // expected receive-event bit, R10
  function automatic logic exp_evt();
    logic ctl;
    ctl = (ethertype == 16'h8808) && arc_hit;
    return (irq_en[0] && ctl) || (irq_en[1] && crc_err) || (irq_en[2] && !crc_err);
  endfunction

  // expected status word, R9
  function automatic logic [31:0] exp_word();
    logic [31:0] w;
    logic [3:0]  c;
    c     = exp_code();
    w     = '0;
    w[3:0] = c;
    w[4]  = c[3];
    w[5]  = (ethertype == 16'h8808) && arc_hit;
    w[6]  = exp_evt();
    w[7]  = crc_err;
    w[8]  = !crc_err;
    w[17] = is_mcast;
    w[18] = is_bcast;
    return w;
  endfunction

  task automatic scramble();
    ethertype = 16'($urandom);
    is_bcast  = 1'($urandom);
    is_mcast  = 1'($urandom);
    arc_hit   = 1'($urandom);
    cam_hit   = 1'($urandom);
    cmp_en    = 1'($urandom);
    filt_mode = 2'($urandom);
    acc_mask  = 3'($urandom);
    pass_ctl  = 1'($urandom);
    short_en  = 1'($urandom);
    crc_err   = 1'($urandom);
    irq_en    = 3'($urandom);
    case ($urandom_range(0, 3))
      0: frame_len = 11'($urandom_range(0, 16));
      1: frame_len = 11'($urandom_range(60, 68));
      default: frame_len = 11'($urandom_range(64, 1518));
    endcase
    if ($urandom_range(0, 3) == 0) ethertype = 16'h8808;
  endtask

  // fields are set by the caller before the call
  task automatic run_frame(input string tag);
    logic [31:0] w;
    logic        ei;
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    chk("R2 cleared status", status, 32'h0);
    chk("R2 cleared irq", {31'h0, irq}, 32'h0);
    w  = exp_word();
    ei = w[6] && w[4];
    eof = 1'b1;
    @(negedge clk); eof = 1'b0;
    chk("R3 result valid", {31'h0, res_vld}, 32'h1);
    chk({tag, " code"}, {28'h0, filt_code}, {28'h0, w[3:0]});
    chk("R9 status word", status, w);
    chk("R9 keep pin", {31'h0, keep}, {31'h0, w[4]});
    chk("R10 irq", {31'h0, irq}, {31'h0, ei});
    scramble();
    @(negedge clk);
    chk("R3 pulse ends", {31'h0, res_vld}, 32'h0);
    chk("R3 status held", status, w);
    chk("R3 irq held", {31'h0, irq}, {31'h0, ei});
  endtask

  task automatic base(input logic [1:0] m, input logic [LEN_W-1:0] len);
    ethertype = 16'h0800; is_bcast = 0; is_mcast = 0; arc_hit = 0; cam_hit = 0;
    cmp_en = 0; filt_mode = m; acc_mask = 3'b111; pass_ctl = 0; short_en = 0;
    crc_err = 0; irq_en = 3'b111; frame_len = len;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", status, 32'h3E00_8000);
    chk("R1 reset irq", {31'h0, irq}, 32'h0);
    chk("R3 no pulse after reset", {31'h0, res_vld}, 32'h0);

    // R4 control frames
    base(2'b00, 11'd64); ethertype = 16'h8808; arc_hit = 1; run_frame("R4 ctl toss");
    base(2'b01, 11'd64); ethertype = 16'h8808; arc_hit = 1; pass_ctl = 1; run_frame("R4 ctl pass");
    // R5 length boundaries
    base(2'b01, 11'd5);  run_frame("R5 len5 runt");
    base(2'b01, 11'd5);  short_en = 1; run_frame("R5 len5 short");
    base(2'b01, 11'd6);  run_frame("R5 len6");
    base(2'b01, 11'd63); arc_hit = 1; run_frame("R5 len63");
    base(2'b01, 11'd64); arc_hit = 1; run_frame("R5 len64");
    base(2'b01, 11'd13); short_en = 1; arc_hit = 1; run_frame("R5 len13 short");
    base(2'b01, 11'd14); short_en = 1; arc_hit = 1; run_frame("R5 len14 short");
    // R6 inverse mode
    base(2'b00, 11'd100); arc_hit = 1; cam_hit = 1; run_frame("R6 inv arc");
    base(2'b00, 11'd100); cam_hit = 1; run_frame("R6 inv cam");
    base(2'b00, 11'd100); run_frame("R6 inv none");
    // R7 AND mode
    base(2'b01, 11'd100); cam_hit = 1; run_frame("R7 and cam");
    base(2'b01, 11'd100); cmp_en = 1; run_frame("R7 and miss");
    base(2'b01, 11'd100); run_frame("R7 and nocmp");
    // R8 accept mode and reserved mode
    base(2'b10, 11'd100); arc_hit = 1; is_bcast = 1; is_mcast = 1; acc_mask = 3'b011; run_frame("R8 bcast masked");
    base(2'b10, 11'd100); arc_hit = 1; is_mcast = 1; acc_mask = 3'b010; run_frame("R8 mcast ok");
    base(2'b11, 11'd100); arc_hit = 1; run_frame("R8 mode11");
    // R10 tossed frame: event set, no irq
    base(2'b00, 11'd100); arc_hit = 1; crc_err = 1; run_frame("R10 toss event");
    base(2'b01, 11'd100); arc_hit = 1; irq_en = 3'b000; run_frame("R10 disabled");

    // R1 soft reset after a result
    base(2'b01, 11'd100); arc_hit = 1; run_frame("R7 pre soft");
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    chk("R1 soft reset status", status, 32'h3E00_8000);
    chk("R1 soft reset irq", {31'h0, irq}, 32'h0);

    for (int n = 0; n < 400; n++) begin
      scramble();
      run_frame("R6 R7 R8 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule